// File: doc/BRIEF.md
# Validated Clock Source Selector

This block holds the source choice for every clock consumer in a clock generation unit. The consumers are two safe outputs, a set of general outputs, seven fractional-divider inputs and the PLL input. Each consumer has one 32-bit control word. The word carries a 5-bit source code and some free configuration bits, and bit 0 of the word is an enable. A write to a word always stores the configuration bits. The source code is stored only if the code is legal for that consumer and the chosen clock is running at that moment. If either test fails, the old code stays in place. Software reads the word back to find out whether its choice was taken.

One activity detector watches each of the twelve candidate clocks. It uses the register clock as a reference. A toggle flop in the source domain goes through a synchronizer. Every change the synchronizer passes on restarts a small window counter. A clock with no edge for 8 reference cycles counts as dead. Every consumer drives a gated clock output that comes from a mux steered by its stored code. The clock mux is a behavioural model and is not glitch-free.

Top module: `clk_src_guard`

## Requirements
- R1: After reset, every control word reads as zero. Every stored source code is 0, the low-power oscillator, and every clock output is low.
- R2: Source codes are: 0 low-power oscillator, 1 crystal, 2/3/4 PLL at base, double and quadruple rate, 5 to 11 dividers 0 to 6. A general output (words 2 to 5) accepts any code from 0 to 11 when that source is active. Several consumers may hold the same code.
- R3: The two safe outputs (words 0 and 1) accept only code 0. Any other code leaves their stored code unchanged.
- R4: Divider inputs (words 6 to 12) accept only codes 0 to 4. Any divider code (5 to 11) is refused, including the divider's own code.
- R5: The PLL input (word 13) accepts only code 0 or 1. PLL-output and divider codes are refused.
- R6: Codes 12 to 31 are refused for every word. A stored code never leaves the range 0 to 11.
- R7: On a refused write, bits [31:29] and [23:0] still take the written data in the same cycle. Only the code field keeps its old value.
- R8: A source with no rising edge for 8 reference cycles is inactive, and a write selecting it is refused. Once its edges return, the same write is accepted.
- R9: A read returns {config[31:29], code[4:0], config[23:0]} of the addressed word, with the code in bits [28:24]. Addresses 14 and 15 read as zero, and writes to them change nothing.
- R10: Each clock output equals the clock of its stored source while bit 0 of its word is 1, and is held low while that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | register and reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| src_clk | input | 12 | candidate source clocks, index equals source code |
| wr_en | input | 1 | write strobe |
| wr_addr | input | 4 | word index to write |
| wr_data | input | 32 | write data |
| rd_addr | input | 4 | word index to read |
| rd_data | output | 32 | read data of the addressed word |
| sel_flat | output | 70 | stored 5-bit code of every word, word 0 in the low bits |
| clk_out | output | 14 | gated clock per word |

## Verification
The bench targets self-selection by a divider and PLL feedback through its own outputs. A design that checked only the code range would store those codes and make a loop. The bench also writes words whose config bits and code change together. A design that refuses the whole word would lose the config bits, and one that refuses nothing would overwrite the code. The bench stops a PLL output and later restarts it. A detector with the wrong window or a stale synchronizer would accept a dead clock, or keep refusing one that has come back. It also writes to the two unused addresses, where a decode that aliases them would corrupt a real word.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int SEL_W = 5;
  localparam int CODE_LP = 0;
  localparam int CODE_XTAL = 1;

  localparam int KIND_SAFE = 0;
  localparam int KIND_GEN = 1;
  localparam int KIND_DIV = 2;
  localparam int KIND_PLL = 3;

  // Legality of a source code for a consumer kind.
  function automatic logic code_ok(int kind, logic [SEL_W-1:0] code,
                                   int n_pll, int n_div);
    int c;
    c = int'(code);
    case (kind)
      KIND_SAFE: code_ok = (c == CODE_LP);
      KIND_GEN:  code_ok = (c < 2 + n_pll + n_div);
      KIND_DIV:  code_ok = (c < 2 + n_pll);
      default:   code_ok = (c == CODE_LP) || (c == CODE_XTAL);
    endcase
  endfunction

  // Consumer kind from word index.
  function automatic int kind_of(int idx, int n_gen, int n_div);
    if (idx < 2) kind_of = KIND_SAFE;
    else if (idx < 2 + n_gen) kind_of = KIND_GEN;
    else if (idx < 2 + n_gen + n_div) kind_of = KIND_DIV;
    else kind_of = KIND_PLL;
  endfunction
endpackage

// File: rtl/csg_act_det.sv
module csg_act_det #(
  parameter int WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  input  logic mon_rst_n,
  output logic active
);
  localparam int CW = $clog2(WIN + 1);

  logic tog_q;
  logic s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic edge_seen;

  // Source domain: toggle once per monitored rising edge.
  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) tog_q <= 1'b0;
    else            tog_q <= ~tog_q;
  end

  // Reference domain: synchronize and detect changes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tog_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_seen = s2_q ^ s3_q;

  always_comb begin
    cnt_d = cnt_q;
    if (edge_seen) cnt_d = '0;
    else if (cnt_q != CW'(WIN)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(WIN);
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != CW'(WIN));

  assert_edge_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> active);
endmodule

// File: rtl/csg_slot.sv
module csg_slot
  import csg_pkg::*;
#(
  parameter int KIND  = KIND_GEN,
  parameter int N_SRC = 12,
  parameter int N_PLL = 3,
  parameter int N_DIV = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [31:0]      wr_data,
  input  logic [N_SRC-1:0] src_active,
  input  logic [N_SRC-1:0] src_clk,
  output logic [SEL_W-1:0] sel,
  output logic [31:0]      word,
  output logic             clk_out
);
  localparam int PADW = 1 << SEL_W;

  logic [SEL_W-1:0] sel_q, sel_d, wr_code;
  logic [26:0]      cfg_q, cfg_d;
  logic [PADW-1:0]  act_pad, clk_pad;
  logic             code_take;

  assign act_pad = {{(PADW-N_SRC){1'b0}}, src_active};
  assign clk_pad = {{(PADW-N_SRC){1'b0}}, src_clk};
  assign wr_code = wr_data[28:24];

  always_comb begin
    code_take = wr_stb && code_ok(KIND, wr_code, N_PLL, N_DIV) && act_pad[wr_code];
    sel_d = code_take ? wr_code : sel_q;
    cfg_d = wr_stb ? {wr_data[31:29], wr_data[23:0]} : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_W'(CODE_LP);
      cfg_q <= '0;
    end else begin
      sel_q <= sel_d;
      cfg_q <= cfg_d;
    end
  end

  assign sel     = sel_q;
  assign word    = {cfg_q[26:24], sel_q, cfg_q[23:0]};
  assign clk_out = cfg_q[0] & clk_pad[sel_q];

  assert_dead_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !act_pad[wr_code]) |=> $stable(sel_q));
  assert_cfg_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (cfg_q == {$past(wr_data[31:29]), $past(wr_data[23:0])}));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(sel_q) && $stable(cfg_q)));
  assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < N_SRC);

  if (KIND == KIND_SAFE) begin : g_safe_chk
    assert_safe_lp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q == SEL_W'(CODE_LP));
  end
endmodule

// File: rtl/clk_src_guard.sv
module clk_src_guard
  import csg_pkg::*;
#(
  parameter int N_GEN = 4,
  parameter int N_DIV = 7,
  parameter int N_PLL = 3,
  parameter int WIN   = 8,
  localparam int N_SRC = 2 + N_PLL + N_DIV,
  localparam int N_REG = 2 + N_GEN + N_DIV + 1,
  localparam int AW    = $clog2(N_REG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [31:0]            rd_data,
  output logic [N_REG*SEL_W-1:0] sel_flat,
  output logic [N_REG-1:0]       clk_out
);
  logic rst_meta_q, rst_q;
  logic [N_SRC-1:0] src_active;
  logic [31:0] word [N_REG];

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_det
    csg_act_det #(.WIN(WIN)) det_i (
      .clk      (clk),
      .rst_n    (rst_q),
      .mon_clk  (src_clk[s]),
      .mon_rst_n(rst_n),
      .active   (src_active[s])
    );
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_slot
    localparam int KND = kind_of(r, N_GEN, N_DIV);
    logic stb;
    assign stb = wr_en && (wr_addr == AW'(r));
    csg_slot #(.KIND(KND), .N_SRC(N_SRC), .N_PLL(N_PLL), .N_DIV(N_DIV)) slot_i (
      .clk       (clk),
      .rst_n     (rst_q),
      .wr_stb    (stb),
      .wr_data   (wr_data),
      .src_active(src_active),
      .src_clk   (src_clk),
      .sel       (sel_flat[r*SEL_W +: SEL_W]),
      .word      (word[r]),
      .clk_out   (clk_out[r])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (rd_addr == AW'(r)) rd_data = word[r];
    end
  end
endmodule

// File: tb/clk_src_guard_tb.sv
module clk_src_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 12;
  localparam int N_REG = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_SRC-1:0] sclk;
  logic [N_SRC-1:0] run;
  logic wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [N_REG*5-1:0] sel_flat;
  logic [N_REG-1:0] clk_out;

  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;
  logic [31:0] m_word [N_REG];

  clk_src_guard dut_i (
    .clk(clk), .rst_n(rst_n), .src_clk(sclk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sel_flat(sel_flat), .clk_out(clk_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Source i toggles every 2*(i+1) ns; all toggles land on even times.
  initial begin
    int cnt [N_SRC];
    sclk = '0;
    for (int i = 0; i < N_SRC; i++) cnt[i] = 0;
    forever begin
      #2;
      for (int i = 0; i < N_SRC; i++) begin
        cnt[i]++;
        if (cnt[i] == i + 1) begin
          cnt[i] = 0;
          if (run[i]) sclk[i] = ~sclk[i];
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic legal(int r, int code);
    if (code > 11) return 1'b0;
    if (r < 2) return code == 0;
    if (r < 6) return 1'b1;
    if (r < 13) return code <= 4;
    return code <= 1;
  endfunction

  // Every cycle: stored codes, addressed read word and gated clocks.
  always @(negedge clk) begin
    if (mon_on) begin
      for (int r = 0; r < N_REG; r++) begin
        logic [4:0] es;
        logic eo;
        es = m_word[r][28:24];
        eo = m_word[r][0] & sclk[es];
        chk(sel_flat[r*5 +: 5] == es, "R2/R6 model sel", 32'(sel_flat[r*5 +: 5]), 32'(es));
        chk(clk_out[r] == eo, "R10 model clk_out", 32'(clk_out[r]), 32'(eo));
      end
      if (rd_addr < 4'(N_REG))
        chk(rd_data == m_word[rd_addr], "R9 model read", rd_data, m_word[rd_addr]);
      else
        chk(rd_data == 32'h0, "R9 model unmapped read", rd_data, 32'h0);
    end
  end

  task automatic wr(input int r, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'(r);
    wr_data = d;
    @(posedge clk);
    if (r < N_REG) begin
      int code;
      logic [31:0] nw;
      code = int'(d[28:24]);
      nw = d;
      if (!(legal(r, code) && run[code])) nw[28:24] = m_word[r][28:24];
      m_word[r] = nw;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int r, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 4'(r);
    #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  function automatic logic [31:0] mk(input logic [4:0] code, input logic [26:0] cfg);
    return {cfg[26:24], code, cfg[23:0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run = '1;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    for (int r = 0; r < N_REG; r++) m_word[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(sel_flat == '0, "R1 reset codes", 32'(sel_flat[31:0]), 32'h0);
    chk(clk_out == '0, "R1 reset clk_out", 32'(clk_out), 32'h0);
    for (int r = 0; r < N_REG; r++) rd_chk(r, 32'h0, "R1 reset word");
    repeat (20) @(negedge clk);
    mon_on = 1'b1;

    // R2 general outputs, sharing
    wr(2, mk(5'd11, 27'h0000_0A1));
    rd_chk(2, mk(5'd11, 27'h0000_0A1), "R2 gen divider6");
    wr(3, mk(5'd4, 27'h5123_457));
    wr(5, mk(5'd4, 27'h0000_003));
    rd_chk(5, mk(5'd4, 27'h0000_003), "R2 shared pll x4");
    wr(4, mk(5'd1, 27'h0000_001));
    rd_chk(4, mk(5'd1, 27'h0000_001), "R2 gen crystal");

    // R3 safe outputs
    wr(0, mk(5'd1, 27'h0ABC_DE1));
    rd_chk(0, mk(5'd0, 27'h0ABC_DE1), "R3 safe refuses crystal, R7 cfg kept");
    wr(1, mk(5'd2, 27'h7000_001));
    rd_chk(1, mk(5'd0, 27'h7000_001), "R3 safe refuses pll");

    // R4 divider inputs
    wr(6, mk(5'd5, 27'h0000_011));
    rd_chk(6, mk(5'd0, 27'h0000_011), "R4 divider self refused");
    wr(6, mk(5'd3, 27'h0000_021));
    rd_chk(6, mk(5'd3, 27'h0000_021), "R4 divider pll x2");
    wr(7, mk(5'd3, 27'h0000_001));
    wr(7, mk(5'd7, 27'h0000_0F1));
    rd_chk(7, mk(5'd3, 27'h0000_0F1), "R4 divider from divider refused, R7");

    // R5 PLL input
    wr(13, mk(5'd2, 27'h0000_001));
    rd_chk(13, mk(5'd0, 27'h0000_001), "R5 pll feedback refused");
    wr(13, mk(5'd9, 27'h0000_001));
    rd_chk(13, mk(5'd0, 27'h0000_001), "R5 pll from divider refused");
    wr(13, mk(5'd1, 27'h0000_001));
    rd_chk(13, mk(5'd1, 27'h0000_001), "R5 pll crystal");

    // R6 out-of-range codes, R7 config still written
    wr(2, mk(5'd12, 27'h1234_561));
    rd_chk(2, mk(5'd11, 27'h1234_561), "R6 code 12 refused");
    wr(2, mk(5'd31, 27'h0000_001));
    rd_chk(2, mk(5'd11, 27'h0000_001), "R6 code 31 refused");

    // R8 dead source refused, accepted once running again
    run[3] = 1'b0;
    repeat (25) @(negedge clk);
    wr(4, mk(5'd3, 27'h0000_041));
    rd_chk(4, mk(5'd1, 27'h0000_041), "R8 dead pll x2 refused");
    run[3] = 1'b1;
    repeat (25) @(negedge clk);
    wr(4, mk(5'd3, 27'h0000_041));
    rd_chk(4, mk(5'd3, 27'h0000_041), "R8 revived pll x2 accepted");

    // R10 enable gating
    wr(3, mk(5'd4, 27'h0000_000));
    repeat (12) begin
      @(negedge clk);
      chk(clk_out[3] == 1'b0, "R10 disabled output low", 32'(clk_out[3]), 32'h0);
      chk(clk_out[2] == sclk[11], "R10 enabled follows source", 32'(clk_out[2]), 32'(sclk[11]));
    end

    // R9 unmapped addresses
    wr(14, 32'hFFFF_FFFF);
    wr(15, mk(5'd1, 27'h7FF_FFFF));
    rd_chk(14, 32'h0, "R9 addr 14 reads zero");
    rd_chk(15, 32'h0, "R9 addr 15 reads zero");
    rd_chk(0, mk(5'd0, 27'h0ABC_DE1), "R9 word 0 untouched");
    rd_chk(1, mk(5'd0, 27'h7000_001), "R9 word 1 untouched");

    repeat (5) @(negedge clk);
    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule